// File: doc/BRIEF.md
# Code-Steered Complex Despreading ALU

This block is a two-operand, one-result integer arithmetic unit with a registered output. Besides the usual add, subtract, AND, OR and a byte picker, it multiplies a packed complex word by a complex code whose two parts are each +1 or −1. In despreading correlation, such a product is usually formed with branches. Here the code chips are loaded once as a 16-bit group into a pair of internal code registers. Each later complex operation then takes the next real/imaginary chip pair as its own add-or-subtract selectors, so the product comes out as a plain sum or difference.

A controller presents one operation per clock on `op_code` with `op_valid`, and the two operands on `opnd_a` and `opnd_b`. The result appears on `result` one clock later, and `res_valid` marks cycles that carry a fresh result. A load operation writes new chips and rewinds the chip pointer. Complex operations step through the chips two at a time and go back to the first pair after the last one.

Top module: `cbw_alu`

## Requirements
- R1: While reset is asserted and after it is released, with no operation yet issued, `result` is 0 and `res_valid` is 0. The code registers hold all zeros and the chip pointer is at pair 0.
- R2: op_code 0 (add) and 1 (subtract, `opnd_a - opnd_b`) give a 32-bit wrapping result with `res_valid` high, exactly one clock after the operation is accepted.
- R3: op_code 2 gives the bitwise AND and op_code 3 gives the bitwise OR of the operands, with the same one-clock latency.
- R4: op_code 4 (byte select) returns byte n of `opnd_a`, zero-extended, where n = `opnd_b[1:0]`. Byte 0 is `opnd_a[7:0]` and byte 3 is `opnd_a[31:24]`.
- R5: op_code 5 (load) stores `opnd_a[15:0]` as the code group and sets the chip pointer to pair 0. It drives `res_valid` low the next cycle and leaves `result` unchanged. A complex operation in the very next cycle already uses the new chips.
- R6: op_code 6 (complex multiply) takes Ir = `opnd_a[15:0]` and Ii = `opnd_a[31:16]`. It uses chip pair k: real chip cr = code bit 2k and imaginary chip ci = code bit 2k+1, where chip value 0 means +1 and 1 means −1. It returns real part cr·Ir − ci·Ii in `result[15:0]` and imaginary part cr·Ii + ci·Ir in `result[31:16]`, each wrapping at 16 bits.
- R7: Each complex multiply moves the chip pointer on by one pair. After the eighth pair, the next complex multiply uses pair 0 again.
- R8: Add, subtract, AND, OR and byte select do not move the chip pointer.
- R9: When `op_valid` is low, or op_code is 7 (no-op), `res_valid` is low the next cycle. `result` and the chip pointer stay unchanged.
- R10: `opnd_b` has no effect on load or on complex multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation selector (encodings in R2–R9) |
| opnd_a | input | 32 | First operand; packed complex word for complex multiply; code group source for load |
| opnd_b | input | 32 | Second operand; byte index in bits [1:0] for byte select |
| result | output | 32 | Registered result |
| res_valid | output | 1 | `result` was produced by the operation of the previous cycle |

## Verification
A wrong chip pointer or corrupted code register does not show up on any arithmetic operation. It shows only on the next complex multiply, as one or both 16-bit halves having the wrong sign. A pointer that fails to wrap, or that steps on non-complex operations, shows up within at most eight complex multiplies, when the sign pattern drifts from the loaded code group. The bench therefore loads code groups with distinct patterns for every pair and mixes other operations between complex multiplies. It compares every cycle, so a sign error is caught the cycle after the offending operation.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_BSEL = 3'd4,
        OP_LOAD = 3'd5,
        OP_CMUL = 3'd6,
        OP_NOP  = 3'd7
    } op_e;

endpackage

// File: rtl/cbw_code_bank.sv
module cbw_code_bank #(
    parameter int unsigned CODE_W = 16,
    localparam int unsigned PAIRS = CODE_W / 2,
    localparam int unsigned PTR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [CODE_W-1:0] load_bits,
    input  logic              step_en,
    output logic              chip_re,
    output logic              chip_im
);

    typedef struct packed {
        logic [PAIRS-1:0] re_bits;
        logic [PAIRS-1:0] im_bits;
        logic [PTR_W-1:0] ptr;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [PAIRS-1:0] split_re;
    logic [PAIRS-1:0] split_im;

    // even positions feed the real chip register, odd ones the imaginary
    for (genvar k = 0; k < PAIRS; k++) begin : g_split
        assign split_re[k] = load_bits[2*k];
        assign split_im[k] = load_bits[2*k+1];
    end

    always_comb begin
        bank_d = bank_q;
        if (load_en) begin
            bank_d.re_bits = split_re;
            bank_d.im_bits = split_im;
            bank_d.ptr     = '0;
        end else if (step_en) begin
            if (bank_q.ptr == PTR_W'(PAIRS - 1)) begin
                bank_d.ptr = '0;
            end else begin
                bank_d.ptr = bank_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign chip_re = bank_q.re_bits[bank_q.ptr];
    assign chip_im = bank_q.im_bits[bank_q.ptr];

endmodule

// File: rtl/cbw_basic_unit.sv
module cbw_basic_unit
    import cbw_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned NBYTES = DATA_W / 8,
    localparam int unsigned SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    logic [7:0] lane [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = a[8*g +: 8];
    end

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_BSEL: y = {{(DATA_W-8){1'b0}}, lane[b[SEL_W-1:0]]};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/cbw_cmul_unit.sv
module cbw_cmul_unit #(
    parameter int unsigned HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] a,
    input  logic                chip_re,
    input  logic                chip_im,
    output logic [2*HALF_W-1:0] y
);

    logic [HALF_W-1:0] in_re, in_im;
    logic [HALF_W-1:0] re_by_cr, im_by_ci, im_by_cr, re_by_ci;

    function automatic logic [HALF_W-1:0] signed_by(input logic [HALF_W-1:0] v,
                                                    input logic neg);
        return neg ? (~v + 1'b1) : v;
    endfunction

    assign in_re = a[HALF_W-1:0];
    assign in_im = a[2*HALF_W-1:HALF_W];

    always_comb begin
        re_by_cr = signed_by(in_re, chip_re);
        im_by_ci = signed_by(in_im, chip_im);
        im_by_cr = signed_by(in_im, chip_re);
        re_by_ci = signed_by(in_re, chip_im);
        y[HALF_W-1:0]        = re_by_cr - im_by_ci;
        y[2*HALF_W-1:HALF_W] = im_by_cr + re_by_ci;
    end

endmodule

// File: rtl/cbw_alu.sv
module cbw_alu
    import cbw_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CODE_W = 16,
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              res_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              vld;
    } out_t;

    out_t out_d, out_q;

    op_e               op;
    logic              chip_re, chip_im;
    logic              is_load, is_cmul, is_basic;
    logic [DATA_W-1:0] basic_y, cmul_y;

    assign op       = op_e'(op_code);
    assign is_load  = op_valid && (op == OP_LOAD);
    assign is_cmul  = op_valid && (op == OP_CMUL);
    assign is_basic = op_valid && (op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_BSEL});

    cbw_code_bank #(.CODE_W(CODE_W)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (is_load),
        .load_bits (opnd_a[CODE_W-1:0]),
        .step_en   (is_cmul),
        .chip_re   (chip_re),
        .chip_im   (chip_im)
    );

    cbw_basic_unit #(.DATA_W(DATA_W)) i_basic (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (basic_y)
    );

    cbw_cmul_unit #(.HALF_W(HALF_W)) i_cmul (
        .a       (opnd_a),
        .chip_re (chip_re),
        .chip_im (chip_im),
        .y       (cmul_y)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        if (is_basic) begin
            out_d.res = basic_y;
            out_d.vld = 1'b1;
        end else if (is_cmul) begin
            out_d.res = cmul_y;
            out_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result    = out_q.res;
    assign res_valid = out_q.vld;

endmodule

// File: rtl/cbw_alu_chk.sv
module cbw_alu_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] result,
    input logic              res_valid
);

    // R2
    add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0) |=> (res_valid && result == $past(opnd_a + opnd_b)));

    // R3
    or_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd3) |=> (res_valid && result == $past(opnd_a | opnd_b)));

    // R4
    bsel_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd4) |=> (result[DATA_W-1:8] == '0));

    // R5
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |=> (!res_valid && $stable(result)));

    // R6
    cmul_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd6) |=> res_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == 3'd7) |=> (!res_valid && $stable(result)));

endmodule

bind cbw_alu cbw_alu_chk #(.DATA_W(DATA_W)) i_cbw_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .res_valid (res_valid)
);

// File: tb/test_cbw_alu.sv
module test_cbw_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd7;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        res_valid;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    logic [15:0] m_code = '0;
    int          m_ptr  = 0;
    logic [31:0] e_res  = '0;
    logic        e_val  = 1'b0;
    string       e_req  = "R1";

    always #4 clk = ~clk;

    cbw_alu i_cbw_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .res_valid (res_valid)
    );

    task automatic compare();
        n_run++;
        if (result !== e_res || res_valid !== e_val) begin
            n_fail++;
            $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                     e_req, result, res_valid, e_res, e_val);
        end
    endtask

    function automatic logic [31:0] ref_cmul(input logic [31:0] a, input bit cr, input bit ci);
        int ir, ii, r, im;
        ir = int'(a[15:0]);
        ii = int'(a[31:16]);
        r  = (cr ? -ir : ir) - (ci ? -ii : ii);
        im = (cr ? -ii : ii) + (ci ? -ir : ir);
        return {im[15:0], r[15:0]};
    endfunction

    // check outputs of the previous operation, then present a new one
    task automatic cyc(input bit vld, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b);
        @(negedge clk);
        compare();
        op_valid = vld;
        op_code  = op;
        opnd_a   = a;
        opnd_b   = b;
        e_val    = 1'b0;
        if (!vld || op == 3'd7) begin
            e_req = "R9";
        end else begin
            case (op)
                3'd0: begin e_res = a + b; e_val = 1'b1; e_req = "R2"; end
                3'd1: begin e_res = a - b; e_val = 1'b1; e_req = "R2"; end
                3'd2: begin e_res = a & b; e_val = 1'b1; e_req = "R3"; end
                3'd3: begin e_res = a | b; e_val = 1'b1; e_req = "R3"; end
                3'd4: begin
                    e_res = 32'((a >> (8 * int'(b[1:0]))) & 32'hFF);
                    e_val = 1'b1;
                    e_req = "R4";
                end
                3'd5: begin m_code = a[15:0]; m_ptr = 0; e_req = "R5"; end
                default: begin
                    e_res = ref_cmul(a, m_code[2*m_ptr], m_code[2*m_ptr+1]);
                    e_val = 1'b1;
                    m_ptr = (m_ptr + 1) % 8;
                    e_req = "R6 R7";
                end
            endcase
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs during and after reset
        repeat (3) @(negedge clk);
        e_req = "R1";
        compare();
        rst_n = 1'b1;
        cyc(1'b0, 3'd7, '0, '0);
        // R1: zero code means +1,+1 at pair 0
        cyc(1'b1, 3'd6, 32'h0003_0005, '0);
        // R2 / R3 directed
        cyc(1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0002);
        cyc(1'b1, 3'd1, 32'h0000_0001, 32'h0000_0003);
        cyc(1'b1, 3'd2, 32'hF0F0_1234, 32'h0FF0_FFFF);
        cyc(1'b1, 3'd3, 32'hF000_0001, 32'h0F00_0010);
        // R4 each byte index
        for (int n = 0; n < 4; n++) cyc(1'b1, 3'd4, 32'hA1B2_C3D4, 32'hFFFF_FFFC | n);
        // R5 / R10: load with garbage b, then walk pairs; R8: basic ops interleaved
        cyc(1'b1, 3'd5, 32'hDEAD_B4E1, 32'h1234_5678);
        for (int n = 0; n < 9; n++) begin
            cyc(1'b1, 3'd6, 32'h8001_7FFF, 32'(n * 32'h0101_0101));
            cyc(1'b1, 3'd0, 32'h1, 32'h2);
        end
        // R9: idle and no-op hold result
        cyc(1'b0, 3'd0, 32'h5555_5555, 32'h1);
        cyc(1'b1, 3'd7, 32'h5555_5555, 32'h1);
        cyc(1'b1, 3'd6, 32'h0010_0020, '0);
        // R7: full wrap with a fresh group
        cyc(1'b1, 3'd5, 32'h0000_1E69, '0);
        for (int n = 0; n < 17; n++) cyc(1'b1, 3'd6, 32'h0100_0200 + 32'(n), 32'hFFFF_FFFF);
        // mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            if (op == 3'd5 && $urandom_range(0, 3) != 0) op = 3'd6;
            cyc($urandom_range(0, 9) != 0, op, $urandom, $urandom);
        end
        cyc(1'b0, 3'd7, '0, '0);
        cyc(1'b0, 3'd7, '0, '0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule